// File: doc/BRIEF.md
# Two-Core Interrupt Distributor

This block collects interrupt requests from three classes of source and hands each of two processor cores the single most urgent request that is waiting for it. IDs 0 to 15 are raised by software through a trigger register. IDs 16 to 31 are private to each core and come from per-core lines. IDs 32 to 47 come from shared system peripherals and are steered to cores by a per-ID target mask. Every ID carries an enable bit and a 4-bit priority. Each tracked interrupt moves through a four-state life cycle: Inactive, Pending, Active, and Active-and-Pending. Software-triggered and private IDs keep a separate copy of this state for each core. Shared IDs keep one copy, plus the core that owns it while it is being serviced.

Each core's interface sees an offered ID, or the spurious value 1023 when nothing qualifies. The core accepts the offered ID with an acknowledge pulse. When service is complete, it returns the ID with an end-of-interrupt pulse. Configuration goes through a plain synchronous register port. Writes take effect at the clock edge. Read data follows the address combinationally.

Register map, with a 16-bit data bus:
- Address 0x00 is the control register. Bit 0 is the global enable.
- Address 0x01 is the trigger register, which is write-only.
- Addresses 0x40 + n, for n from 0 to 47, are the per-ID configuration registers.

Top module: `irq_distributor`

## Requirements
- R1: After reset the global enable is 0, every interrupt is Inactive, both `irqValid` bits are 0, both `irqId` fields read 1023, and every configuration register reads 0.
- R2: A write to address 0x01 makes the software ID in data bits [3:0] Pending on the cores named as follows. If data bit 8 is 1, the ID goes to all cores. Otherwise it goes to the cores whose bits are set in data bits [5:4], where bit 4 is core 0. This pending state persists until that core acknowledges it.
- R3: Private ID 16+k follows line `ppiLine[c*16+k]` for core c only. Its state on one core is independent of the same ID on the other core.
- R4: A shared ID is offered to core c only while bit c of its target field, configuration bits [9:8], is 1. Its pending bit follows `spiLine[n-32]`.
- R5: An ID is offered only while the global enable (control bit 0) and its own enable (configuration bit 0) are both 1. While no ID qualifies, `irqValid` is 0 and `irqId` is 1023.
- R6: Among the qualifying IDs, a core is offered the one with the lowest priority value (configuration bits [7:4]). A tie goes to the lowest ID. Only IDs in the Pending state qualify.
- R7: An acknowledge pulse from a core moves the offered ID to Active. It moves to Active-and-Pending instead if its source is still asserted or it is re-triggered. In neither state is the ID offered.
- R8: An end-of-interrupt pulse naming an ID that is Active on that core clears the active part of its state. This leaves the ID Inactive, or Pending if it was Active-and-Pending, and a Pending ID is offered again. An end-of-interrupt for an ID that is not active on that core has no effect.
- R9: A shared ID acknowledged by one core is offered to no core until the owning core sends its end-of-interrupt. An end-of-interrupt for that ID from the other core is ignored.
- R10: If both cores acknowledge the same shared ID in one cycle, core 0 becomes its owner and core 1's acknowledge has no effect.
- R11: The control register reads back the global enable. A configuration register reads back enable, priority and, for shared IDs only, the targets. For other IDs the target bits read 0. Address 0x01 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 8 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data for `regAddr` |
| ppiLine | input | 32 | Per-core private lines, core c in bits [c*16+15:c*16] |
| spiLine | input | 16 | Shared peripheral lines for IDs 32 to 47 |
| irqValid | output | 2 | Core c has an offered interrupt |
| irqId | output | 20 | Offered ID per core, core c in bits [c*10+9:c*10]; 1023 if none |
| ackReq | input | 2 | Acknowledge pulse per core |
| eoiReq | input | 2 | End-of-interrupt pulse per core |
| eoiId | input | 20 | ID returned with the end-of-interrupt, core c in bits [c*10+9:c*10] |

## Verification
The assertions assume that a core pulses `ackReq` only in a cycle in which it is being offered an ID. They also assume that `eoiReq` carries an ID that the same core acknowledged earlier, or a deliberately stale one meant to be ignored. The bench sequences every acknowledge right after checking the offered ID, and it drives each pulse for exactly one cycle at the falling edge. Shared lines are held steady across each check, so the level-following pending bit stays predictable. All source changes are spaced one edge before the offered ID is sampled.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int NCORE  = 2;
  localparam int NSGI   = 16;
  localparam int NPPI   = 16;
  localparam int NSPI   = 16;
  localparam int NBANK  = NSGI + NPPI;
  localparam int NID    = NBANK + NSPI;
  localparam int IDX_W  = $clog2(NID);
  localparam int BIDX_W = $clog2(NBANK);
  localparam int SIDX_W = $clog2(NSPI);
  localparam int SGI_W  = $clog2(NSGI);
  localparam int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 4;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;

  localparam logic [ID_W-1:0]   SPURIOUS_ID = '1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_SGI    = 8'h01;
  localparam logic [ADDR_W-1:0] CFG_BASE    = 8'h40;

  localparam int CFG_PRIO_LSB = 4;
  localparam int CFG_TGT_LSB  = 8;
  localparam int SGI_MASK_LSB = 4;
  localparam int SGI_ALL_BIT  = 8;

  typedef struct packed {
    logic                        ctrlWr;
    logic                        sgiWr;
    logic                        cfgWr;
    logic                        rdCtrl;
    logic                        rdCfg;
    logic [IDX_W-1:0]            cfgIdx;
    logic [DATA_W-1:0]           data;
    logic [NCORE-1:0]            sgiMask;
    logic [SGI_W-1:0]            sgiIdx;
    logic [NCORE-1:0]            eoiHit;
    logic [NCORE-1:0][IDX_W-1:0] eoiIdx;
  } strobe_t;
endpackage

// File: rtl/irqd_ctrl.sv
module irqd_ctrl
  import irqd_pkg::*;
(
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic [NCORE-1:0]      eoiReq,
  input  logic [NCORE*ID_W-1:0] eoiId,
  output strobe_t               stb
);
  logic [ADDR_W-1:0] cfgOff;
  logic              inCfg;
  logic [ID_W-1:0]   eid;

  always_comb begin
    cfgOff = regAddr - CFG_BASE;
    inCfg  = (regAddr >= CFG_BASE) && (cfgOff < ADDR_W'(NID));
    stb        = '0;
    stb.data   = regWrData;
    stb.ctrlWr = regWrEn && (regAddr == ADDR_CTRL);
    stb.sgiWr  = regWrEn && (regAddr == ADDR_SGI);
    stb.cfgWr  = regWrEn && inCfg;
    stb.rdCtrl = (regAddr == ADDR_CTRL);
    stb.rdCfg  = inCfg;
    stb.cfgIdx = cfgOff[IDX_W-1:0];
    stb.sgiIdx = regWrData[SGI_W-1:0];
    if (stb.sgiWr)
      stb.sgiMask = regWrData[SGI_ALL_BIT] ? '1 : regWrData[SGI_MASK_LSB +: NCORE];
    eid = '0;
    for (int c = 0; c < NCORE; c++) begin
      eid = eoiId[c*ID_W +: ID_W];
      stb.eoiHit[c] = eoiReq[c] && (eid < ID_W'(NID));
      stb.eoiIdx[c] = eid[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/irqd_arb.sv
module irqd_arb
  import irqd_pkg::*;
(
  input  logic [NID-1:0]             cand,
  input  logic [NID-1:0][PRIO_W-1:0] prio,
  output logic                       offerValid,
  output logic [IDX_W-1:0]           offerIdx,
  output logic [ID_W-1:0]            offerId
);
  logic [PRIO_W-1:0] bestP;

  // strict less-than while scanning upward keeps the lowest ID on a tie
  always_comb begin
    offerValid = 1'b0;
    offerIdx   = '0;
    bestP      = '1;
    for (int i = 0; i < NID; i++) begin
      if (cand[i] && (!offerValid || prio[i] < bestP)) begin
        offerValid = 1'b1;
        bestP      = prio[i];
        offerIdx   = IDX_W'(i);
      end
    end
    offerId = offerValid ? ID_W'(offerIdx) : SPURIOUS_ID;
  end
endmodule

// File: rtl/irqd_state.sv
module irqd_state
  import irqd_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  strobe_t                           stb,
  input  logic [NCORE-1:0][NPPI-1:0]        ppiLine,
  input  logic [NSPI-1:0]                   spiLine,
  input  logic [NCORE-1:0]                  ackTake,
  input  logic [NCORE-1:0][IDX_W-1:0]       ackIdx,
  output logic [NCORE-1:0][NID-1:0]         cand,
  output logic [NID-1:0][PRIO_W-1:0]        prio,
  output logic                              gEnOut,
  output logic [DATA_W-1:0]                 rdData
);
  // state bit 0 = pending, bit 1 = active
  logic                               gEn;
  logic [NID-1:0]                     en;
  logic [NID-1:0][PRIO_W-1:0]         prioQ;
  logic [NSPI-1:0][NCORE-1:0]         tgt;
  logic [NCORE-1:0][NBANK-1:0][1:0]   bankSt, bankNx;
  logic [NSPI-1:0][1:0]               spiSt, spiNx;
  logic [NSPI-1:0][CORE_W-1:0]        spiOwner, ownNx;
  logic                               hitAck, hitEoi, take, drop;
  logic [CORE_W-1:0]                  who;
  logic [IDX_W-1:0]                   ackOff0;
  logic                               unusedBits;

  assign ackOff0    = ackIdx[0] - IDX_W'(NBANK);
  assign unusedBits = ^{stb.data[DATA_W-1:CFG_TGT_LSB+NCORE], stb.data[CFG_PRIO_LSB-1:1],
                        ackOff0[IDX_W-1:SIDX_W]};
  assign gEnOut = gEn;
  assign prio   = prioQ;

  always_comb begin
    bankNx = bankSt;
    spiNx  = spiSt;
    ownNx  = spiOwner;
    hitAck = 1'b0; hitEoi = 1'b0; take = 1'b0; drop = 1'b0; who = '0;
    for (int c = 0; c < NCORE; c++) begin
      for (int i = 0; i < NSGI; i++) begin
        hitAck = ackTake[c] && (ackIdx[c] == IDX_W'(i));
        hitEoi = stb.eoiHit[c] && (stb.eoiIdx[c] == IDX_W'(i));
        bankNx[c][i][1] = (bankSt[c][i][1] && !hitEoi) || hitAck;
        bankNx[c][i][0] = (bankSt[c][i][0] && !hitAck) ||
                          (stb.sgiMask[c] && (stb.sgiIdx == SGI_W'(i)));
      end
      for (int k = 0; k < NPPI; k++) begin
        hitAck = ackTake[c] && (ackIdx[c] == IDX_W'(NSGI + k));
        hitEoi = stb.eoiHit[c] && (stb.eoiIdx[c] == IDX_W'(NSGI + k));
        bankNx[c][NSGI+k][1] = (bankSt[c][NSGI+k][1] && !hitEoi) || hitAck;
        bankNx[c][NSGI+k][0] = ppiLine[c][k];
      end
    end
    for (int j = 0; j < NSPI; j++) begin
      take = 1'b0; drop = 1'b0; who = '0;
      for (int c = 0; c < NCORE; c++) begin
        if (!take && ackTake[c] && (ackIdx[c] == IDX_W'(NBANK + j))) begin
          take = 1'b1;
          who  = CORE_W'(c);
        end
        if (stb.eoiHit[c] && (stb.eoiIdx[c] == IDX_W'(NBANK + j)) &&
            (spiOwner[j] == CORE_W'(c)))
          drop = 1'b1;
      end
      spiNx[j] = {(spiSt[j][1] && !drop) || take, spiLine[j]};
      if (take) ownNx[j] = who;
    end
  end

  always_comb begin
    for (int c = 0; c < NCORE; c++) begin
      for (int i = 0; i < NBANK; i++)
        cand[c][i] = gEn && en[i] && (bankSt[c][i] == 2'b01);
      for (int j = 0; j < NSPI; j++)
        cand[c][NBANK+j] = gEn && en[NBANK+j] && (spiSt[j] == 2'b01) && tgt[j][c];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gEn      <= 1'b0;
      en       <= '0;
      prioQ    <= '0;
      tgt      <= '0;
      bankSt   <= '0;
      spiSt    <= '0;
      spiOwner <= '0;
    end else begin
      bankSt   <= bankNx;
      spiSt    <= spiNx;
      spiOwner <= ownNx;
      if (stb.ctrlWr) gEn <= stb.data[0];
      if (stb.cfgWr) begin
        en[stb.cfgIdx]    <= stb.data[0];
        prioQ[stb.cfgIdx] <= stb.data[CFG_PRIO_LSB +: PRIO_W];
      end
      for (int j = 0; j < NSPI; j++)
        if (stb.cfgWr && (stb.cfgIdx == IDX_W'(NBANK + j)))
          tgt[j] <= stb.data[CFG_TGT_LSB +: NCORE];
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.rdCtrl) rdData[0] = gEn;
    else if (stb.rdCfg) begin
      rdData[0] = en[stb.cfgIdx];
      rdData[CFG_PRIO_LSB +: PRIO_W] = prioQ[stb.cfgIdx];
      for (int j = 0; j < NSPI; j++)
        if (stb.cfgIdx == IDX_W'(NBANK + j)) rdData[CFG_TGT_LSB +: NCORE] = tgt[j];
    end
  end

  for (genvar gc = 0; gc < NCORE; gc++) begin : g_chk
    a_r2_sgi_pending: assert property (@(posedge clk) disable iff (!rstN)
      stb.sgiMask[gc] |=> bankSt[gc][BIDX_W'($past(stb.sgiIdx))][0]);
    a_r7_ack_active: assert property (@(posedge clk) disable iff (!rstN)
      (ackTake[gc] && ackIdx[gc] < IDX_W'(NBANK))
      |=> bankSt[gc][$past(ackIdx[gc][BIDX_W-1:0])][1]);
    a_r8_eoi_clears: assert property (@(posedge clk) disable iff (!rstN)
      (stb.eoiHit[gc] && stb.eoiIdx[gc] < IDX_W'(NBANK) &&
       !(ackTake[gc] && ackIdx[gc] == stb.eoiIdx[gc]))
      |=> !bankSt[gc][$past(stb.eoiIdx[gc][BIDX_W-1:0])][1]);
  end

  if (NCORE > 1) begin : g_own
    a_r10_core0_owns: assert property (@(posedge clk) disable iff (!rstN)
      (ackTake[0] && ackTake[1] && ackIdx[0] == ackIdx[1] && ackIdx[0] >= IDX_W'(NBANK))
      |=> spiOwner[$past(ackOff0[SIDX_W-1:0])] == '0);
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [NCORE*NPPI-1:0] ppiLine,
  input  logic [NSPI-1:0]       spiLine,
  output logic [NCORE-1:0]      irqValid,
  output logic [NCORE*ID_W-1:0] irqId,
  input  logic [NCORE-1:0]      ackReq,
  input  logic [NCORE-1:0]      eoiReq,
  input  logic [NCORE*ID_W-1:0] eoiId
);
  strobe_t                      stb;
  logic [NCORE-1:0][NID-1:0]    cand;
  logic [NID-1:0][PRIO_W-1:0]   prio;
  logic [NCORE-1:0][IDX_W-1:0]  offerIdx;
  logic [NCORE-1:0]             ackTake;
  logic [NCORE-1:0][NPPI-1:0]   ppiByCore;
  logic                         gEn;

  assign ppiByCore = ppiLine;
  assign ackTake   = ackReq & irqValid;

  irqd_ctrl u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .eoiReq(eoiReq), .eoiId(eoiId), .stb(stb)
  );

  irqd_state u_state (
    .clk(clk), .rstN(rstN), .stb(stb), .ppiLine(ppiByCore), .spiLine(spiLine),
    .ackTake(ackTake), .ackIdx(offerIdx), .cand(cand), .prio(prio),
    .gEnOut(gEn), .rdData(regRdData)
  );

  for (genvar gc = 0; gc < NCORE; gc++) begin : g_core
    irqd_arb u_arb (
      .cand(cand[gc]), .prio(prio), .offerValid(irqValid[gc]),
      .offerIdx(offerIdx[gc]), .offerId(irqId[gc*ID_W +: ID_W])
    );
  end

  a_r5_global_gate: assert property (@(posedge clk) disable iff (!rstN)
    !gEn |-> irqValid == '0);
endmodule

// File: tb/irq_distributor_test.sv
module irq_distributor_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [31:0] ppiLine = '0;
  logic [15:0] spiLine = '0;
  logic [1:0]  irqValid;
  logic [19:0] irqId;
  logic [1:0]  ackReq = '0;
  logic [1:0]  eoiReq = '0;
  logic [19:0] eoiId = '0;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_distributor uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .ppiLine(ppiLine),
    .spiLine(spiLine), .irqValid(irqValid), .irqId(irqId),
    .ackReq(ackReq), .eoiReq(eoiReq), .eoiId(eoiId)
  );

  // {shared lines, expected core0 ID, expected core1 ID}
  localparam logic [35:0] VEC [0:7] = '{
    {16'h0001, 10'd32,   10'd1023},
    {16'h0003, 10'd32,   10'd33},
    {16'h0006, 10'd34,   10'd33},
    {16'h0014, 10'd34,   10'd34},
    {16'h0019, 10'd35,   10'd36},
    {16'h0060, 10'd1023, 10'd1023},
    {16'h007F, 10'd35,   10'd33},
    {16'h0000, 10'd1023, 10'd1023}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic both(input string tag, input int e0, input int e1);
    chk(tag, int'(irqId[9:0]), e0);
    chk(tag, int'(irqId[19:10]), e1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input int exp);
    regAddr = a;
    #1;
    chk(tag, int'(regRdData), exp);
  endtask

  task automatic ack(input logic [1:0] m);
    ackReq = m;
    tick();
    ackReq = '0;
  endtask

  task automatic eoi(input int c, input int id);
    eoiReq[c] = 1'b1;
    eoiId[c*10 +: 10] = 10'(id);
    tick();
    eoiReq = '0;
  endtask

  task automatic finish();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 valid", int'(irqValid), 0);
    both("R1 id", 1023, 1023);
    rdChk("R1 ctrl", 8'h00, 0);
    rdChk("R1 cfg", 8'h40 + 8'd40, 0);

    // shared ID configuration: tgt<<8 | prio<<4 | en
    wr(8'h60, 16'h0181);
    wr(8'h61, 16'h0231);
    wr(8'h62, 16'h0331);
    wr(8'h63, 16'h0111);
    wr(8'h64, 16'h0331);
    wr(8'h65, 16'h0001);
    wr(8'h66, 16'h0350);
    wr(8'h54, 16'h03F1);
    rdChk("R11 shared cfg", 8'h62, 'h331);
    rdChk("R11 disabled cfg", 8'h66, 'h350);
    rdChk("R11 private drops tgt", 8'h54, 'h0F1);
    rdChk("R11 trigger reads 0", 8'h01, 0);

    // R5 global enable gate
    spiLine = 16'h0001;
    tick();
    both("R5 gate off", 1023, 1023);
    wr(8'h00, 16'h0001);
    chk("R5 gate on", int'(irqId[9:0]), 32);
    rdChk("R11 ctrl", 8'h00, 1);
    spiLine = '0;
    tick();

    // R4/R6/R5 routing and arbitration table
    for (int v = 0; v < 8; v++) begin
      spiLine = VEC[v][35:20];
      tick();
      chk("R4 R6 core0", int'(irqId[9:0]), int'(VEC[v][19:10]));
      chk("R4 R6 core1", int'(irqId[19:10]), int'(VEC[v][9:0]));
    end

    // R2 software trigger
    wr(8'h43, 16'h0021);
    wr(8'h45, 16'h0021);
    wr(8'h01, 16'h0025);
    both("R2 subset", 1023, 5);
    wr(8'h01, 16'h0103);
    both("R2 all R6 tie", 3, 3);
    ack(2'b01);
    both("R7 ack core0", 1023, 3);
    ack(2'b10);
    both("R7 ack core1", 1023, 5);
    wr(8'h01, 16'h0013);
    both("R7 active pending hidden", 1023, 5);
    eoi(0, 3);
    both("R8 eoi to pending", 3, 5);
    ack(2'b01);
    eoi(0, 3);
    both("R8 eoi to inactive", 1023, 5);
    ack(2'b10);
    eoi(1, 5);
    eoi(1, 3);
    both("R8 core1 drained", 1023, 1023);

    // R3 private lines per core
    wr(8'h54, 16'h0011);
    ppiLine = 32'h0010_0000;
    tick();
    both("R3 core1 only", 1023, 20);
    ppiLine = 32'h0010_0010;
    tick();
    both("R3 both", 20, 20);
    ack(2'b01);
    both("R3 R7 independent", 1023, 20);
    eoi(0, 20);
    both("R8 level reasserts", 20, 20);
    ack(2'b01);
    ppiLine = 32'h0010_0000;
    tick();
    eoi(0, 20);
    both("R8 eoi inactive", 1023, 20);
    ppiLine = '0;
    tick();
    both("R3 idle", 1023, 1023);

    // R9 exclusivity of shared IDs
    spiLine = 16'h0004;
    tick();
    both("R9 offered both", 34, 34);
    ack(2'b01);
    both("R9 hidden", 1023, 1023);
    eoi(1, 34);
    spiLine = '0;
    tick();
    spiLine = 16'h0004;
    tick();
    both("R9 foreign eoi ignored", 1023, 1023);
    eoi(0, 34);
    both("R9 owner eoi", 34, 34);

    // R10 simultaneous acknowledge
    ack(2'b11);
    both("R10 both ack", 1023, 1023);
    spiLine = '0;
    tick();
    eoi(1, 34);
    spiLine = 16'h0004;
    tick();
    both("R10 core1 not owner", 1023, 1023);
    eoi(0, 34);
    both("R10 core0 owner", 34, 34);
    spiLine = '0;
    tick();
    both("R10 idle", 1023, 1023);

    finish();
  end
endmodule